// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block moves 36-bit words from a producer clock domain to a consumer clock domain. The two clocks run freely and may be unrelated, or they may be one and the same net. Storage is a two-port memory whose depth is a parameter (256, 512 or 1024 words). Write and read positions cross between the domains as Gray-coded counters that are one bit wider than the address, and each crossing passes through a two-stage synchronizer. Every status flag is a register computed in the domain that consumes it.

The producer side accepts a word on a rising write-clock edge when its select, direction and enable inputs and its ready flag are all high. It raises a level flag once the stored count exceeds a programmable threshold. The consumer side presents the oldest word at its output with a valid flag, in first-word-fall-through style, and consumes that word on a rising read-clock edge when select and enable are high. It raises a low-level flag while the count is at or below a second programmable threshold.

Both thresholds come from a mode input that is sampled during reset. In three of its codes the mode gives fixed values. In the fourth, the first two words written after reset are taken as the two thresholds, and neither of them enters the queue.

Top module: `dcf_pflag_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, `in_ready` and `out_ready` are driven low. After reset, with no traffic, the block settles to `in_ready`=1, `out_ready`=0, `almost_empty`=1 and `almost_full`=0.
- R2: A word is accepted only on a rising `wclk` edge where `wsel`, `wdir`, `wen` and `in_ready` are all 1. A cycle with `wdir`=0 or `wsel`=0 stores nothing.
- R3: Words leave in exactly the order they were accepted, with all 36 bits intact. This holds when the two clocks are the same signal and a write and a read fall on one edge, and it holds when the clocks are unrelated.
- R4: The queue holds at most DEPTH words. When it holds DEPTH words, `in_ready` is 0 and write attempts leave both the contents and the count unchanged.
- R5: `out_ready`=1 means `rdata` shows the oldest stored word. That word is consumed on a rising `rclk` edge where `rsel`, `ren` and `out_ready` are all 1. A read attempt while `out_ready` is 0 has no effect.
- R6: Once synchronization has settled, `almost_full` is 1 exactly when the stored count is greater than the full threshold.
- R7: Once synchronization has settled, `almost_empty` is 1 exactly when the stored count is at or below the empty threshold.
- R8: With `fs_sel`=2'b00 during reset, the first accepted write after reset loads the empty threshold from `wdata[AW:0]`, and the second loads the full threshold in the same way. Neither word is queued. After that, both thresholds stay constant until the next reset.
- R9: With `fs_sel` set to 2'b01, 2'b10 or 2'b11 during reset, both thresholds are set to 8, 16 or 64 respectively. Normal writes then start at once.
- R10: The write position reaches the read domain, and the read position reaches the write domain, only as Gray code through two register stages. The flags therefore follow a change on the other side after a bounded delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| fs_sel | input | 2 | Threshold mode, sampled during reset |
| wsel | input | 1 | Write-side select |
| wdir | input | 1 | Direction; 1 allows a write |
| wen | input | 1 | Write enable |
| wdata | input | 36 | Write data, also used to carry the threshold values |
| in_ready | output | 1 | Space available; a write is accepted this edge |
| almost_full | output | 1 | Count is above the full threshold |
| rclk | input | 1 | Read-side clock |
| rsel | input | 1 | Read-side select |
| ren | input | 1 | Read enable |
| rdata | output | 36 | Oldest word, valid while out_ready is 1 |
| out_ready | output | 1 | A word is present at rdata |
| almost_empty | output | 1 | Count is at or below the empty threshold |

## Verification
The functions most likely to collide are a write accepted and a read consumed on the same rising edge. With a shared clock, the write-position update, the read-position update and the output fetch all act together on that edge. The bench provokes this by driving `rclk` from the write clock and running a writer and a reader in parallel, each with its own gap pattern, so that many edges carry both a write and a read. The result is judged by comparing every word that comes out against the arithmetic pattern for its index, and then checking that all four flags return to the empty-queue values. A second phase uses unrelated clocks and sweeps the stored count from zero to full and back, checking each flag against its threshold at every level.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int WORD_W = 36;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    OFS_BUS = 2'b00,
    OFS_8   = 2'b01,
    OFS_16  = 2'b10,
    OFS_64  = 2'b11
  } ofs_mode_e;

  function automatic logic [15:0] preset_offset(input ofs_mode_e m);
    case (m)
      OFS_8:   return 16'd8;
      OFS_16:  return 16'd16;
      OFS_64:  return 16'd64;
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic [15:0] to_gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [15:0] from_gray(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    fs_sel,
  input  logic          wsel,
  input  logic          wdir,
  input  logic          wen,
  input  word_t         wdata,
  input  logic [PW-1:0] rgray_in,
  output logic          in_ready,
  output logic          almost_full,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] ae_off
);
  logic [PW-1:0] wbin, wbin_n, rgray_s, rsync_bin, level_w, af_off;
  logic [1:0]    ld_stage;
  logic          ld_done, req;

  dcf_sync #(.W(PW)) u_rsync (.clk(clk), .rst(rst), .d(rgray_in), .q(rgray_s));

  assign rsync_bin = PW'(from_gray(16'(rgray_s)));
  assign req       = wsel & wdir & wen & in_ready;
  assign ld_done   = (ld_stage == 2'd2);
  assign push      = req & ld_done;
  assign wbin_n    = wbin + PW'(push);
  assign level_w   = wbin_n - rsync_bin;
  assign waddr     = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin        <= '0;
      wgray       <= '0;
      in_ready    <= 1'b0;
      almost_full <= 1'b0;
      ae_off      <= PW'(preset_offset(ofs_mode_e'(fs_sel)));
      af_off      <= PW'(preset_offset(ofs_mode_e'(fs_sel)));
      ld_stage    <= (ofs_mode_e'(fs_sel) == OFS_BUS) ? 2'd0 : 2'd2;
    end else begin
      wbin        <= wbin_n;
      wgray       <= PW'(to_gray(16'(wbin_n)));
      in_ready    <= (level_w != PW'(DEPTH));
      almost_full <= (level_w > af_off);
      if (req && !ld_done) begin
        if (ld_stage == 2'd0) ae_off <= wdata[PW-1:0];
        else                  af_off <= wdata[PW-1:0];
        ld_stage <= ld_stage + 2'd1;
      end
    end
  end

  // R4
  wr_level_chk: assert property (@(posedge clk) disable iff (rst)
    (wbin - rsync_bin) <= PW'(DEPTH));

  // R2
  wr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wbin != $past(wbin)) |-> ($past(in_ready) && (wbin == $past(wbin) + PW'(1))));

  // R8
  ofs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_done && $past(ld_done)) |-> ($stable(af_off) && $stable(ae_off)));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rsel,
  input  logic          ren,
  input  logic [PW-1:0] wgray_in,
  input  logic [PW-1:0] ae_off,
  output logic          out_ready,
  output logic          almost_empty,
  output logic          fetch,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray
);
  logic [PW-1:0] rbin, rbin_n, wgray_s, wsync_bin, avail;
  logic          pop;

  dcf_sync #(.W(PW)) u_wsync (.clk(clk), .rst(rst), .d(wgray_in), .q(wgray_s));

  assign wsync_bin = PW'(from_gray(16'(wgray_s)));
  assign pop       = rsel & ren & out_ready;
  assign rbin_n    = rbin + PW'(pop);
  assign avail     = wsync_bin - rbin_n;
  assign fetch     = (avail != '0) && (!out_ready || pop);
  assign raddr     = rbin_n[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin         <= '0;
      rgray        <= '0;
      out_ready    <= 1'b0;
      almost_empty <= 1'b1;
    end else begin
      rbin         <= rbin_n;
      rgray        <= PW'(to_gray(16'(rbin_n)));
      almost_empty <= (avail <= ae_off);
      if (fetch)    out_ready <= 1'b1;
      else if (pop) out_ready <= 1'b0;
    end
  end

  // R5
  rd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rbin != $past(rbin)) |-> $past(out_ready));

  // R5
  valid_word_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> (wsync_bin != rbin));

  // R4
  rd_level_chk: assert property (@(posedge clk) disable iff (rst)
    (wsync_bin - rbin) <= PW'(DEPTH));
endmodule

// File: rtl/dcf_pflag_fifo.sv
module dcf_pflag_fifo
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              wclk,
  input  logic              rst,
  input  logic [1:0]        fs_sel,
  input  logic              wsel,
  input  logic              wdir,
  input  logic              wen,
  input  logic [WORD_W-1:0] wdata,
  output logic              in_ready,
  output logic              almost_full,
  input  logic              rclk,
  input  logic              rsel,
  input  logic              ren,
  output logic [WORD_W-1:0] rdata,
  output logic              out_ready,
  output logic              almost_empty
);
  word_t         mem [DEPTH];
  logic          push, fetch;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, ae_off;

  // R4
  initial depth_param_chk: assert (DEPTH == 256 || DEPTH == 512 || DEPTH == 1024)
    else $error("unsupported depth %0d", DEPTH);

  dcf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk(wclk), .rst(rst), .fs_sel(fs_sel), .wsel(wsel), .wdir(wdir),
    .wen(wen), .wdata(wdata), .rgray_in(rgray), .in_ready(in_ready),
    .almost_full(almost_full), .push(push), .waddr(waddr), .wgray(wgray),
    .ae_off(ae_off)
  );

  dcf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .clk(rclk), .rst(rst), .rsel(rsel), .ren(ren), .wgray_in(wgray),
    .ae_off(ae_off), .out_ready(out_ready), .almost_empty(almost_empty),
    .fetch(fetch), .raddr(raddr), .rgray(rgray)
  );

  always_ff @(posedge wclk) begin
    if (push) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (fetch) rdata <= mem[raddr];
  end
endmodule

// File: tb/dcf_pflag_fifo_tb.sv
`timescale 1ns/100ps
module dcf_pflag_fifo_tb;
  localparam int DEPTH = 256;

  logic        wclk = 1'b0, aclk = 1'b0, share = 1'b0;
  logic        rclk;
  logic        rst = 1'b1;
  logic [1:0]  fs_sel = 2'b00;
  logic        wsel = 1'b0, wdir = 1'b0, wen = 1'b0;
  logic [35:0] wdata = '0;
  logic        rsel = 1'b0, ren = 1'b0;
  logic        in_ready, almost_full, out_ready, almost_empty;
  logic [35:0] rdata;
  int          n_cmp = 0, n_bad = 0;

  always #5   wclk = ~wclk;
  always #3.5 aclk = ~aclk;
  assign rclk = share ? wclk : aclk;

  dcf_pflag_fifo #(.DEPTH(DEPTH)) u_dut (
    .wclk(wclk), .rst(rst), .fs_sel(fs_sel), .wsel(wsel), .wdir(wdir),
    .wen(wen), .wdata(wdata), .in_ready(in_ready), .almost_full(almost_full),
    .rclk(rclk), .rsel(rsel), .ren(ren), .rdata(rdata),
    .out_ready(out_ready), .almost_empty(almost_empty)
  );

  function automatic logic [35:0] pat(input int i);
    return {4'(i), (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge wclk);
    repeat (8) @(posedge rclk);
    @(negedge wclk);
  endtask

  task automatic check_flags(input int lvl, input int aeo, input int afo);
    chk("R6 almost_full", 64'(almost_full), 64'(lvl > afo));
    chk("R7 almost_empty", 64'(almost_empty), 64'(lvl <= aeo));
    chk("R4 in_ready", 64'(in_ready), 64'(lvl < DEPTH));
    chk("R5 out_ready", 64'(out_ready), 64'(lvl > 0));
  endtask

  task automatic wr_word(input logic [35:0] d);
    @(negedge wclk);
    while (!in_ready) @(negedge wclk);
    wsel = 1'b1; wdir = 1'b1; wen = 1'b1; wdata = d;
    @(negedge wclk);
    wsel = 1'b0; wdir = 1'b0; wen = 1'b0;
  endtask

  task automatic rd_word(output logic [35:0] d);
    @(negedge rclk);
    while (!out_ready) @(negedge rclk);
    d = rdata; rsel = 1'b1; ren = 1'b1;
    @(negedge rclk);
    rsel = 1'b0; ren = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] fs);
    @(negedge wclk);
    fs_sel = fs; rst = 1'b1;
    repeat (10) @(negedge wclk);
    chk("R1 in_ready in reset", 64'(in_ready), 64'd0);
    chk("R1 out_ready in reset", 64'(out_ready), 64'd0);
    rst = 1'b0;
    settle();
    chk("R1 in_ready after reset", 64'(in_ready), 64'd1);
    chk("R1 out_ready after reset", 64'(out_ready), 64'd0);
    chk("R1 almost_empty after reset", 64'(almost_empty), 64'd1);
    chk("R1 almost_full after reset", 64'(almost_full), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_bad++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [35:0] d;
    // Phase 1: unrelated clocks, thresholds loaded over the data bus (R8)
    share = 1'b0;
    do_reset(2'b00);
    wr_word(36'd5);
    wr_word(36'd250);
    settle();
    chk("R8 threshold words not queued", 64'(out_ready), 64'd0);
    check_flags(0, 5, 250);

    // R6 R7 R10: sweep count up to full
    for (int i = 0; i < DEPTH; i++) begin
      wr_word(pat(i));
      settle();
      check_flags(i + 1, 5, 250);
    end

    // R4: writes while full are ignored
    @(negedge wclk);
    wsel = 1'b1; wdir = 1'b1; wen = 1'b1; wdata = 36'hF_DEAD_BEEF;
    repeat (5) @(negedge wclk);
    wsel = 1'b0; wdir = 1'b0; wen = 1'b0;
    settle();
    check_flags(DEPTH, 5, 250);

    // R3: drain in order, sweeping flags down
    for (int i = 0; i < DEPTH; i++) begin
      rd_word(d);
      chk("R3 order/data", 64'(d), 64'(pat(i)));
      settle();
      check_flags(DEPTH - 1 - i, 5, 250);
    end

    // R5: read attempts while empty are ignored
    @(negedge rclk);
    rsel = 1'b1; ren = 1'b1;
    repeat (5) @(negedge rclk);
    rsel = 1'b0; ren = 1'b0;
    wr_word(pat(999));
    settle();
    check_flags(1, 5, 250);
    rd_word(d);
    chk("R5 word after empty reads", 64'(d), 64'(pat(999)));
    settle();
    check_flags(0, 5, 250);

    // Phase 2: shared clock, preset thresholds (R9)
    share = 1'b1;
    do_reset(2'b01);
    for (int i = 0; i < 10; i++) begin
      wr_word(pat(500 + i));
      settle();
      check_flags(i + 1, 8, 8);
    end

    // R2: wrong direction or deselected port stores nothing
    @(negedge wclk);
    wsel = 1'b1; wdir = 1'b0; wen = 1'b1; wdata = 36'h1_2345_6789;
    @(negedge wclk);
    wsel = 1'b0; wdir = 1'b1;
    @(negedge wclk);
    wsel = 1'b0; wdir = 1'b0; wen = 1'b0;
    settle();
    check_flags(10, 8, 8);
    for (int i = 0; i < 10; i++) begin
      rd_word(d);
      chk("R2 no stray word", 64'(d), 64'(pat(500 + i)));
    end
    settle();
    check_flags(0, 8, 8);

    // R3: concurrent write and read, coincident edges
    fork
      begin
        for (int i = 0; i < 600; i++) begin
          if (i % 7 == 3) repeat (3) @(negedge wclk);
          wr_word(pat(1000 + i));
        end
      end
      begin
        logic [35:0] q;
        for (int j = 0; j < 600; j++) begin
          if (j % 5 == 1) repeat (4) @(negedge rclk);
          rd_word(q);
          chk("R3 shared-edge stream", 64'(q), 64'(pat(1000 + j)));
        end
      end
    join
    settle();
    check_flags(0, 8, 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule